// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block produces the byte addresses for one vectorised load or store, one address per element. A start pulse hands it a base register value with its register selector, a 16-bit signed displacement, the element access size, the vector length, a shift amount and an addressing mode. The block latches these operands and then offers element addresses one at a time on a valid/ready handshake, tagging each with its element index so that the unit writing the register file knows where the data belongs. One cycle after the last address is taken, a done pulse marks the end of the sequence.

Four modes exist. Unit stride walks consecutive elements of the access size past base plus displacement. Element stride uses the displacement itself as the stride, but only for a scalar base with a non-zero displacement; otherwise the block falls back to unit stride. Shifted mode scales the index by displacement and access size and then shifts the product left. Bit-reversed mode does the same after reversing the index over log2 of the vector length, which gives the butterfly order of one radix-2 FFT stage.

Top module: `lsag_top`

## Requirements
- R1: After reset, addr_valid, done and err are all 0.
- R2: Mode 0 (unit stride): element i has address base + sext(disp) + (i << size_log2), where size_log2 values 0,1,2,3 mean 1,2,4,8 bytes.
- R3: Mode 1 (element stride) with base_scalar=1 and disp non-zero gives base + sext(disp) × i; with base_scalar=0 or disp=0 the addresses follow R2.
- R4: Mode 2 (shifted): element i has address base + (((sext(disp) × i) << size_log2) << shamt).
- R5: Mode 3 (bit-reversed): as R4 but with i replaced by i reversed over log2(vlen) bits, so for vlen 4 the order of indices used is 0,2,1,3.
- R6: When base_sel is 0 the base is taken as zero and base_val is ignored.
- R7: The element index on addr_elem runs 0 to vlen-1 and advances only on a cycle with addr_valid and addr_ready both high; while addr_ready is low addr and addr_elem hold.
- R8: done is high for exactly one cycle, the cycle after the last element is accepted, and addr_valid is low from then on.
- R9: A start pulse while a sequence is running has no effect on the running sequence.
- R10: A start with vlen 0, vlen above 64, or mode 3 with vlen not a power of two raises err for one cycle and issues no address.
- R11: Address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request, taken only when idle |
| mode | input | 2 | 0 unit, 1 element stride, 2 shifted, 3 bit-reversed |
| base_sel | input | 5 | Base register selector; 0 means a zero base |
| base_val | input | 64 | Base register contents |
| base_scalar | input | 1 | Base operand is a scalar |
| disp | input | 16 | Signed displacement |
| size_log2 | input | 2 | log2 of access size in bytes |
| vlen | input | 7 | Vector length, 1 to 64 |
| shamt | input | 6 | Left shift for modes 2 and 3 |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | An address is offered |
| addr | output | 64 | Byte effective address |
| addr_elem | output | 6 | Element index of the offered address |
| done | output | 1 | One-cycle pulse after the last accepted address |
| err | output | 1 | One-cycle pulse for a rejected start |

## Verification
A start seen at one rising edge makes the first address and its index visible right after that edge, since the address is formed combinationally from registered operands and index; err for a bad start appears at the same edge. Each accepted address is replaced after the edge at which ready was sampled high, and done appears after the edge that takes the last one. The bench drives inputs and samples outputs on the falling edge, so every comparison lands exactly one edge after the stimulus that caused it, and a cycle with ready low is checked again for the same address.

// File: rtl/lsag_pkg.sv
// Shared mode encoding for the vector load/store address generator.
package lsag_pkg;
    typedef enum logic [1:0] {
        AG_UNIT  = 2'd0,
        AG_ELEM  = 2'd1,
        AG_SHIFT = 2'd2,
        AG_BREV  = 2'd3
    } ag_mode_e;
endpackage

// File: rtl/lsag_cfg_check.sv
// Validates a start command and resolves the effective addressing mode.
// Assumes vlen is an unsigned count; returns log2(vlen) for power-of-two
// lengths (the value is only used in bit-reversed mode).
module lsag_cfg_check
    import lsag_pkg::*;
#(
    parameter int VL_W   = 7,
    parameter int MAX_VL = 64,
    parameter int DISP_W = 16,
    parameter int LVL_W  = 3
) (
    input  ag_mode_e          mode_in,
    input  logic [VL_W-1:0]   vlen,
    input  logic [DISP_W-1:0] disp,
    input  logic              base_scalar,
    output logic              cfg_ok,
    output ag_mode_e          mode_eff,
    output logic [LVL_W-1:0]  levels
);
    logic len_ok;
    logic pow2;

    // Length range and power-of-two test.
    always_comb begin
        len_ok = (vlen != '0) && (32'(vlen) <= MAX_VL);
        pow2   = (vlen & (vlen - VL_W'(1))) == '0;
        cfg_ok = len_ok && ((mode_in != AG_BREV) || pow2);
    end

    // Position of the highest set bit gives log2 for powers of two.
    always_comb begin
        levels = '0;
        for (int b = 0; b < VL_W; b++) begin
            if (vlen[b]) levels = LVL_W'(b);
        end
    end

    // Element stride needs a scalar base and a non-zero displacement.
    always_comb begin
        mode_eff = mode_in;
        if (mode_in == AG_ELEM && (!base_scalar || disp == '0)) mode_eff = AG_UNIT;
    end
endmodule

// File: rtl/lsag_seq.sv
// Element sequencer: holds the running flag and the element index,
// advances on accepted transfers and emits done/err pulses.
// Assumes launch and reject are never high together.
module lsag_seq #(
    parameter int IDX_W = 6,
    parameter int VL_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             reject,
    input  logic [VL_W-1:0]  vlen,
    input  logic             ready,
    output logic             running,
    output logic [IDX_W-1:0] idx,
    output logic             done_p,
    output logic             err_p
);
    logic [IDX_W-1:0] last_idx;

    // Sequence state, index and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
            done_p   <= 1'b0;
            err_p    <= 1'b0;
        end else begin
            done_p <= 1'b0;
            err_p  <= reject;
            if (launch) begin
                running  <= 1'b1;
                idx      <= '0;
                last_idx <= IDX_W'(vlen - VL_W'(1));
            end else if (running && ready) begin
                if (idx == last_idx) begin
                    running <= 1'b0;
                    done_p  <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lsag_offset.sv
// Computes the byte offset from the base for one element index under the
// resolved mode. Purely combinational; assumes levels <= IDX_W.
module lsag_offset
    import lsag_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 6,
    parameter int LVL_W  = 3,
    parameter int SH_W   = 6
) (
    input  ag_mode_e          mode,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        size_log2,
    input  logic [SH_W-1:0]   shamt,
    input  logic [LVL_W-1:0]  levels,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] offset
);
    logic [ADDR_W-1:0] sdisp;
    logic [IDX_W-1:0]  idx_rev;
    logic [ADDR_W-1:0] prod_lin;
    logic [ADDR_W-1:0] prod_rev;

    // Reverse the low 'levels' bits of the index.
    always_comb begin
        idx_rev = '0;
        for (int b = 0; b < IDX_W; b++) begin
            if (LVL_W'(b) < levels) idx_rev[levels - LVL_W'(1) - LVL_W'(b)] = idx[b];
        end
    end

    // Sign extension and index products, modulo 2^ADDR_W.
    always_comb begin
        sdisp    = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        prod_lin = sdisp * ADDR_W'(idx);
        prod_rev = sdisp * ADDR_W'(idx_rev);
    end

    // Mode selection of the final offset.
    always_comb begin
        case (mode)
            AG_UNIT:  offset = sdisp + (ADDR_W'(idx) << size_log2);
            AG_ELEM:  offset = prod_lin;
            AG_SHIFT: offset = (prod_lin << size_log2) << shamt;
            default:  offset = (prod_rev << size_log2) << shamt;
        endcase
    end
endmodule

// File: rtl/lsag_top.sv
// Vector load/store address generator top. Latches operands on an accepted
// start, then offers one address per element on a valid/ready handshake.
// Assumes the consumer may hold ready low for any number of cycles.
module lsag_top
    import lsag_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int SEL_W  = 5,
    parameter int SH_W   = 6,
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int VL_W  = IDX_W + 1,
    localparam int LVL_W = $clog2(VL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              base_scalar,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        size_log2,
    input  logic [VL_W-1:0]   vlen,
    input  logic [SH_W-1:0]   shamt,
    input  logic              addr_ready,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  addr_elem,
    output logic              done,
    output logic              err
);
    logic              cfg_ok;
    ag_mode_e          mode_eff;
    logic [LVL_W-1:0]  lvl_in;
    logic              running;
    logic              launch;
    logic              reject;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] offset;

    ag_mode_e          mode_r;
    logic [ADDR_W-1:0] base_r;
    logic [DISP_W-1:0] disp_r;
    logic [1:0]        size_r;
    logic [SH_W-1:0]   shamt_r;
    logic [LVL_W-1:0]  lvl_r;

    lsag_cfg_check #(
        .VL_W(VL_W), .MAX_VL(MAX_VL), .DISP_W(DISP_W), .LVL_W(LVL_W)
    ) u_cfg (
        .mode_in(ag_mode_e'(mode)), .vlen(vlen), .disp(disp),
        .base_scalar(base_scalar), .cfg_ok(cfg_ok), .mode_eff(mode_eff),
        .levels(lvl_in)
    );

    // Starts are only considered when no sequence is running.
    always_comb begin
        launch = start && !running && cfg_ok;
        reject = start && !running && !cfg_ok;
    end

    lsag_seq #(.IDX_W(IDX_W), .VL_W(VL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .reject(reject),
        .vlen(vlen), .ready(addr_ready), .running(running), .idx(idx),
        .done_p(done), .err_p(err)
    );

    // Operand capture on an accepted start; register 0 reads as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r  <= AG_UNIT;
            base_r  <= '0;
            disp_r  <= '0;
            size_r  <= '0;
            shamt_r <= '0;
            lvl_r   <= '0;
        end else if (launch) begin
            mode_r  <= mode_eff;
            base_r  <= (base_sel == '0) ? '0 : base_val;
            disp_r  <= disp;
            size_r  <= size_log2;
            shamt_r <= shamt;
            lvl_r   <= lvl_in;
        end
    end

    lsag_offset #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W), .LVL_W(LVL_W), .SH_W(SH_W)
    ) u_off (
        .mode(mode_r), .disp(disp_r), .size_log2(size_r), .shamt(shamt_r),
        .levels(lvl_r), .idx(idx), .offset(offset)
    );

    // Output drive: address is base plus offset for the current index.
    always_comb begin
        addr_valid = running;
        addr_elem  = idx;
        addr       = base_r + offset;
    end
endmodule

// File: rtl/lsag_checker.sv
// Protocol checker for lsag_top, attached by bind below.
module lsag_checker #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [ADDR_W-1:0] addr,
    input logic [IDX_W-1:0]  addr_elem,
    input logic              done,
    input logic              err
);
    // R1: reset forces the outputs idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!addr_valid && !done && !err));

    // R7: a stalled offer holds address and index.
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_elem)));

    // R7: an accepted offer is followed by the next index or the end.
    p_index_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready) |=> (!addr_valid || addr_elem == $past(addr_elem) + 1'b1));

    // R7: a new sequence starts at element 0.
    p_first_elem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> (addr_elem == '0));

    // R8: done is a single-cycle pulse after an accepted transfer.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(addr_valid) && $past(addr_ready) && !addr_valid));

    // R10: a rejected start issues nothing.
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!addr_valid && !done));
endmodule

bind lsag_top lsag_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr), .addr_elem(addr_elem), .done(done), .err(err)
);

// File: tb/lsag_top_test.sv
// Self-checking bench for lsag_top: directed corners plus seeded random runs.
module lsag_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [4:0]  base_sel = '0;
    logic [63:0] base_val = '0;
    logic        base_scalar = 1'b0;
    logic [15:0] disp = '0;
    logic [1:0]  size_log2 = '0;
    logic [6:0]  vlen = '0;
    logic [5:0]  shamt = '0;
    logic        addr_ready = 1'b0;
    logic        addr_valid;
    logic [63:0] addr;
    logic [5:0]  addr_elem;
    logic        done;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsag_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_sel(base_sel),
        .base_val(base_val), .base_scalar(base_scalar), .disp(disp),
        .size_log2(size_log2), .vlen(vlen), .shamt(shamt), .addr_ready(addr_ready),
        .addr_valid(addr_valid), .addr(addr), .addr_elem(addr_elem),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Index reversal over lv bits (R5).
    function automatic logic [63:0] rev_idx(input int i, input int lv);
        logic [63:0] r = '0;
        for (int b = 0; b < lv; b++) r[lv-1-b] = i[b];
        return r;
    endfunction

    // Expected address from the requirements (R2..R6, R11).
    function automatic logic [63:0] exp_addr(input logic [1:0] md, input bit scal,
        input logic [4:0] sel, input logic [63:0] bv, input logic [15:0] d,
        input logic [1:0] sz, input logic [5:0] sh, input int vl, input int i);
        logic [63:0] b = (sel == 0) ? 64'd0 : bv;
        logic [63:0] sd = {{48{d[15]}}, d};
        int lv = 0;
        while ((1 << lv) < vl) lv++;
        case (md)
            2'd1: if (scal && d != 0) return b + sd * 64'(i);
                  else return b + sd + (64'(i) << sz);
            2'd2: return b + (((sd * 64'(i)) << sz) << sh);
            2'd3: return b + (((sd * rev_idx(i, lv)) << sz) << sh);
            default: return b + sd + (64'(i) << sz);
        endcase
    endfunction

    task automatic run_seq(input logic [1:0] md, input bit scal, input logic [4:0] sel,
        input logic [63:0] bv, input logic [15:0] d, input logic [1:0] sz,
        input logic [5:0] sh, input int vl, input int rdy_pct, input bit poke,
        input string req);
        int k = 0;
        bit took;
        @(negedge clk);
        mode = md; base_scalar = scal; base_sel = sel; base_val = bv; disp = d;
        size_log2 = sz; shamt = sh; vlen = 7'(vl); start = 1'b1; addr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (k < vl) begin
            chk(addr_valid == 1'b1, {req, " valid"}, 64'(addr_valid), 64'd1);
            chk(addr == exp_addr(md, scal, sel, bv, d, sz, sh, vl, k), req, addr,
                exp_addr(md, scal, sel, bv, d, sz, sh, vl, k));
            chk(addr_elem == 6'(k), "R7 elem", 64'(addr_elem), 64'(k));
            // R9: a start while busy must not disturb the sequence.
            if (poke && k == 1) begin
                start = 1'b1; mode = 2'd0; base_sel = 5'd3; base_val = 64'h5555;
                disp = 16'h0100; vlen = 7'd5;
            end else begin
                start = 1'b0;
            end
            took = (($urandom % 100) < rdy_pct);
            addr_ready = took;
            @(negedge clk);
            if (took) k++;
        end
        start = 1'b0;
        addr_ready = 1'b0;
        chk(done == 1'b1, "R8 done pulse", 64'(done), 64'd1);
        chk(addr_valid == 1'b0, "R8 idle after", 64'(addr_valid), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single", 64'(done), 64'd0);
    endtask

    task automatic run_bad(input logic [1:0] md, input int vl);
        @(negedge clk);
        mode = md; vlen = 7'(vl); base_sel = 5'd1; disp = 16'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R10 err", 64'(err), 64'd1);
        chk(addr_valid == 1'b0, "R10 no addr", 64'(addr_valid), 64'd0);
        @(negedge clk);
        chk(err == 1'b0, "R10 err single", 64'(err), 64'd0);
        chk(addr_valid == 1'b0, "R10 still idle", 64'(addr_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(addr_valid == 1'b0, "R1 valid", 64'(addr_valid), 64'd0);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(err == 1'b0, "R1 err", 64'(err), 64'd0);
        rst_n = 1'b1;

        // R2: word unit stride, base 0x10 disp 8 -> 0x18, 0x1C.
        run_seq(2'd0, 1'b1, 5'd1, 64'h10, 16'd8, 2'd2, 6'd0, 2, 100, 1'b0, "R2 unit");
        // R3: element stride, base 0x10 disp 24 -> 0x10, 0x28.
        run_seq(2'd1, 1'b1, 5'd1, 64'h10, 16'd24, 2'd2, 6'd0, 2, 100, 1'b0, "R3 elem");
        // R3: fallbacks to unit stride (zero disp, vector base).
        run_seq(2'd1, 1'b1, 5'd2, 64'h100, 16'd0, 2'd2, 6'd0, 3, 70, 1'b0, "R3 zero disp");
        run_seq(2'd1, 1'b0, 5'd2, 64'h100, 16'd24, 2'd3, 6'd0, 3, 70, 1'b0, "R3 vector base");
        // R4: shifted with a shift.
        run_seq(2'd2, 1'b1, 5'd4, 64'h2000, 16'd3, 2'd1, 6'd2, 5, 60, 1'b0, "R4 shift");
        // R5: bit-reversed, vlen 4 -> 0x10, 0x18, 0x14, 0x1C.
        run_seq(2'd3, 1'b1, 5'd1, 64'h10, 16'd1, 2'd2, 6'd0, 4, 100, 1'b0, "R5 brev");
        // R6: register 0 reads as zero.
        run_seq(2'd0, 1'b1, 5'd0, 64'hFFFF, 16'd4, 2'd0, 6'd0, 2, 100, 1'b0, "R6 base zero");
        // R11: wrap past 2^64, and negative displacement.
        run_seq(2'd0, 1'b1, 5'd1, 64'hFFFF_FFFF_FFFF_FFF8, 16'd16, 2'd3, 6'd0, 2, 100, 1'b0,
                "R11 wrap");
        run_seq(2'd1, 1'b1, 5'd1, 64'h40, 16'hFFF8, 2'd2, 6'd0, 9, 50, 1'b0, "R11 negative");
        // R9: start during a sequence is ignored; R7: slow consumer.
        run_seq(2'd2, 1'b1, 5'd7, 64'h8000, 16'd2, 2'd2, 6'd1, 6, 30, 1'b1, "R9 ignore start");
        run_seq(2'd0, 1'b1, 5'd7, 64'h0, 16'd0, 2'd0, 6'd0, 64, 90, 1'b0, "R7 max length");
        // R10: rejected starts.
        run_bad(2'd0, 0);
        run_bad(2'd0, 65);
        run_bad(2'd3, 6);

        // Random mix across all modes.
        for (int t = 0; t < 40; t++) begin
            logic [1:0] md = 2'($urandom);
            int vl = (md == 2'd3) ? (1 << ($urandom % 7)) : (1 + ($urandom % 64));
            run_seq(md, 1'($urandom), 5'($urandom), {$urandom, $urandom}, 16'($urandom),
                    2'($urandom), 6'($urandom % 8), vl, 40 + ($urandom % 60),
                    (vl > 2) && ($urandom % 4 == 0), "R2-R5 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule